// File: doc/BRIEF.md
# IR carrier and code transmitter

This block produces the drive signal for an infrared LED. A carrier generator counts system clock cycles and emits a high phase followed by a low phase. The low phase alternates between two programmable lengths, so the average carrier period can be set more finely than one clock. A code sequencer steps through a 32-byte transmit buffer and gates the carrier with a sequence of envelopes. During a high envelope the LED output follows the carrier, and during a low envelope the output is held low.

All envelope timing is counted in ticks of a reference clock of period T. A prescaler divides the system clock by (prescale + 1) to make this tick. The block has two buffer formats. In narrow mode every buffer bit is one envelope: a 1 gives a high envelope of the high base time, and a 0 gives a low envelope of the low base time. In wide mode every pair of bytes is one envelope, and that entry carries its own level and duration. Software fills the buffer through a byte write port, sets the configuration inputs, and pulses `start`. It then waits until `busy` falls.

The controller has two states. ST_IDLE waits for work. ST_SEND plays envelopes and moves between states as follows:
- LAUNCH (ST_IDLE to ST_SEND) is taken on `start` and loads element 0.
- HOLD (ST_SEND to ST_SEND) is taken while the current envelope has time left.
- ADVANCE (ST_SEND to ST_SEND) is taken at the end of an envelope that is not the last, and loads the next element in the same clock.
- FINISH (ST_SEND to ST_IDLE) is taken at the end of the last envelope.

Top module: `irtx_top`

## Requirements
- R1: After reset `busy` is 0 and `led` is 0.
- R2: The carrier waveform is as follows, counted in system clock cycles:
  - a high phase of `cfg_car_high` cycles, then a low phase of `cfg_car_low_a` cycles;
  - another high phase, then a low phase of `cfg_car_low_b` cycles;
  - the pattern then repeats, alternating the two low lengths.
  - A field value of 0 acts as 1.
- R3: The carrier restarts at the first cycle of every envelope. That cycle begins a high phase, and the next low phase uses `cfg_car_low_a`.
- R4: An envelope of N units lasts exactly N*(`cfg_presc`+1) system clock cycles. Consecutive envelopes follow each other with no gap cycle.
- R5: In narrow mode (`cfg_wide`=0), element k is bit (7 - k mod 8) of buffer byte k/8, so the most significant bit of byte 0 is sent first.
  - A 1 bit gives a high envelope of `cfg_base_hi` units.
  - A 0 bit gives a low envelope of `cfg_base_lo` units.
  - A base value of 0 acts as 1.
- R6: In wide mode (`cfg_wide`=1), entry e is the 16-bit value {byte 2e, byte 2e+1}.
  - Bit 15 of the entry is the level (1 = high).
  - Bits 14:0 are the duration in units. A duration of 0 acts as 1.
- R7: `led` equals the carrier during a high envelope. It is 0 during a low envelope and whenever `busy` is 0.
- R8: `busy` rises in the cycle after the clock edge that samples `start` while idle. It stays high for exactly the sum of all envelope lengths in cycles, then falls.
- R9: A `start` pulse while `busy` is 1 has no effect on the waveform or on the duration of `busy`.
- R10: `cfg_last` is the index of the last element sent.
  - In narrow mode it counts bits, so 255 sends the whole 32-byte buffer.
  - In wide mode only its low 4 bits count, and the upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_car_high | input | CW | Carrier high phase length in clocks |
| cfg_car_low_a | input | CW | First low phase length in clocks |
| cfg_car_low_b | input | CW | Second low phase length in clocks |
| cfg_presc | input | PW | Reference tick period minus one, in clocks |
| cfg_base_hi | input | 8 | Narrow mode high envelope length in ticks |
| cfg_base_lo | input | 8 | Narrow mode low envelope length in ticks |
| cfg_wide | input | 1 | 1 selects the 16-bit entry format |
| cfg_last | input | log2(BUF_BYTES*8) | Index of the last element |
| wr_en | input | 1 | Buffer byte write enable |
| wr_addr | input | log2(BUF_BYTES) | Buffer byte address |
| wr_data | input | 8 | Buffer byte data |
| start | input | 1 | Start strobe |
| busy | output | 1 | Transmission in progress |
| led | output | 1 | Infrared LED drive |

## Verification
The bench compares `led` against an arithmetic carrier-and-envelope model in every cycle of each run. It sweeps the prescaler, the high phase length and both low lengths in both buffer formats.

It targets these corner cases, each with the failure it would show:
- **Low-length swap.** A carrier that swaps or never alternates its two low lengths gives a run with a shifted edge.
- **Missing restart.** A carrier that skips the restart at an envelope boundary leaves a broken phase when two high envelopes meet.
- **Prescaler off by one.** A prescaler that is off by one stretches every envelope and lengthens `busy`.
- **Zero-value fields.** Zero-valued fields test the act-as-one rule; a design that reads 0 as 0 would hang or emit nothing.
- **Buffer bounds.** A full 256-bit narrow run and a wide run whose `cfg_last` has stray upper bits expose wrong buffer indexing.
- **Start while busy.** A start pulse in the middle of a transmission would restart a design that does not ignore it.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int BYTE_W = 8;
    localparam int DUR_W  = 2 * BYTE_W - 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_t;

    // A programmed length of zero is treated as one.
    function automatic logic [DUR_W-1:0] at_least_one(input logic [DUR_W-1:0] v);
        return (v == '0) ? DUR_W'(1) : v;
    endfunction

endpackage

// File: rtl/irtx_buf.sv
module irtx_buf #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_a_addr,
    output logic [7:0]    rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [7:0]    rd_b_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];

endmodule

// File: rtl/irtx_presc.sv
module irtx_presc #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [PW-1:0] limit,
    output logic          tick
);

    logic [PW-1:0] cnt;

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + PW'(1);
        end
    end

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] len_high,
    input  logic [CW-1:0] len_low_a,
    input  logic [CW-1:0] len_low_b,
    output logic          car
);

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_t;

    phase_t        phase;
    logic          use_b;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_high;
    logic [CW-1:0] lim_low;
    logic          phase_done;

    always_comb begin
        lim_high = (len_high == '0) ? CW'(1) : len_high;
        if (use_b) begin
            lim_low = (len_low_b == '0) ? CW'(1) : len_low_b;
        end else begin
            lim_low = (len_low_a == '0) ? CW'(1) : len_low_a;
        end
        phase_done = (phase == PH_HIGH) ? (cnt == lim_high - CW'(1))
                                        : (cnt == lim_low - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_HIGH;
            use_b <= 1'b0;
            cnt   <= '0;
        end else if (restart) begin
            phase <= PH_HIGH;
            use_b <= 1'b0;
            cnt   <= '0;
        end else if (phase_done) begin
            cnt <= '0;
            unique case (phase)
                PH_HIGH: phase <= PH_LOW;
                PH_LOW: begin
                    phase <= PH_HIGH;
                    use_b <= ~use_b;
                end
            endcase
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign car = (phase == PH_HIGH);

endmodule

// File: rtl/irtx_top.sv
module irtx_top
    import irtx_pkg::*;
#(
    parameter int BUF_BYTES = 32,
    parameter int CW        = 8,
    parameter int PW        = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [CW-1:0]                     cfg_car_high,
    input  logic [CW-1:0]                     cfg_car_low_a,
    input  logic [CW-1:0]                     cfg_car_low_b,
    input  logic [PW-1:0]                     cfg_presc,
    input  logic [7:0]                        cfg_base_hi,
    input  logic [7:0]                        cfg_base_lo,
    input  logic                              cfg_wide,
    input  logic [$clog2(BUF_BYTES*8)-1:0]    cfg_last,
    input  logic                              wr_en,
    input  logic [$clog2(BUF_BYTES)-1:0]      wr_addr,
    input  logic [7:0]                        wr_data,
    input  logic                              start,
    output logic                              busy,
    output logic                              led
);

    localparam int AW  = $clog2(BUF_BYTES);
    localparam int ELW = AW + 3;
    localparam int EW  = AW - 1;

    tx_state_t      state;
    tx_state_t      state_nxt;
    logic [ELW-1:0] elem;
    logic [ELW-1:0] nxt_idx;
    logic           env_lvl;
    logic [DUR_W-1:0] env_units;
    logic [DUR_W-1:0] ucnt;

    logic [AW-1:0]  rd_a_addr;
    logic [AW-1:0]  rd_b_addr;
    logic [7:0]     rd_a_data;
    logic [7:0]     rd_b_data;

    logic           nxt_lvl;
    logic [DUR_W-1:0] nxt_units;
    logic           tick;
    logic           launch;
    logic           env_end;
    logic           is_last;
    logic           load;
    logic           car;

    irtx_buf #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_a_addr (rd_a_addr),
        .rd_a_data (rd_a_data),
        .rd_b_addr (rd_b_addr),
        .rd_b_data (rd_b_data)
    );

    irtx_presc #(.PW(PW)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .run   (state == ST_SEND),
        .limit (cfg_presc),
        .tick  (tick)
    );

    irtx_carrier #(.CW(CW)) u_car (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (load),
        .len_high  (cfg_car_high),
        .len_low_a (cfg_car_low_a),
        .len_low_b (cfg_car_low_b),
        .car       (car)
    );

    // Element decode: index of the element to load next and its level/length.
    always_comb begin
        nxt_idx = (state == ST_IDLE) ? '0 : elem + ELW'(1);
        if (cfg_wide) begin
            rd_a_addr = {nxt_idx[EW-1:0], 1'b0};
            rd_b_addr = {nxt_idx[EW-1:0], 1'b1};
            nxt_lvl   = rd_a_data[7];
            nxt_units = at_least_one({rd_a_data[6:0], rd_b_data});
        end else begin
            rd_a_addr = nxt_idx[ELW-1:3];
            rd_b_addr = nxt_idx[ELW-1:3];
            nxt_lvl   = rd_a_data[3'd7 - nxt_idx[2:0]];
            nxt_units = at_least_one(DUR_W'(nxt_lvl ? cfg_base_hi : cfg_base_lo));
        end
    end

    always_comb begin
        is_last = cfg_wide ? (elem[EW-1:0] == cfg_last[EW-1:0]) : (elem == cfg_last);
        launch  = (state == ST_IDLE) && start;
        env_end = (state == ST_SEND) && tick && (ucnt == env_units - DUR_W'(1));
        load    = launch || (env_end && !is_last);
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_SEND;
            ST_SEND: if (env_end && is_last) state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Envelope registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elem      <= '0;
            env_lvl   <= 1'b0;
            env_units <= DUR_W'(1);
            ucnt      <= '0;
        end else if (load) begin
            elem      <= nxt_idx;
            env_lvl   <= nxt_lvl;
            env_units <= nxt_units;
            ucnt      <= '0;
        end else if ((state == ST_SEND) && tick) begin
            ucnt <= ucnt + DUR_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        busy = 1'b0;
        led  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                led  = 1'b0;
            end
            ST_SEND: begin
                busy = 1'b1;
                led  = env_lvl & car;
            end
        endcase
    end

endmodule

// File: rtl/irtx_chk.sv
module irtx_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          led,
    input logic          load,
    input logic          car,
    input logic [PW-1:0] cfg_presc
);

    logic [PW-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (!busy && start) begin
            cyc <= '0;
        end else if (busy) begin
            cyc <= (cyc == cfg_presc) ? '0 : cyc + PW'(1);
        end
    end

    assert_idle_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !led);

    assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_env_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> car);

    assert_tick_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load) |-> (cyc == cfg_presc));

endmodule

bind irtx_top irtx_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .led       (led),
    .load      (load),
    .car       (car),
    .cfg_presc (cfg_presc)
);

// File: tb/sim_irtx_top.sv
`timescale 1ns/1ps
module sim_irtx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_car_high = 8'd1;
    logic [7:0] cfg_car_low_a = 8'd1;
    logic [7:0] cfg_car_low_b = 8'd1;
    logic [7:0] cfg_presc = 8'd0;
    logic [7:0] cfg_base_hi = 8'd1;
    logic [7:0] cfg_base_lo = 8'd1;
    logic       cfg_wide = 1'b0;
    logic [7:0] cfg_last = 8'd0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       start = 1'b0;
    logic       busy;
    logic       led;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [7:0] bimg [32];
    bit  exp_led [0:8191];

    always #2 clk = ~clk;

    irtx_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_car_high(cfg_car_high), .cfg_car_low_a(cfg_car_low_a),
        .cfg_car_low_b(cfg_car_low_b), .cfg_presc(cfg_presc),
        .cfg_base_hi(cfg_base_hi), .cfg_base_lo(cfg_base_lo),
        .cfg_wide(cfg_wide), .cfg_last(cfg_last),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .busy(busy), .led(led)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit car_at(input int t, input int h, input int l1, input int l2);
        int hh = (h == 0) ? 1 : h;
        int a  = (l1 == 0) ? 1 : l1;
        int b  = (l2 == 0) ? 1 : l2;
        int r  = t % (2 * hh + a + b);
        return (r < hh) || ((r >= hh + a) && (r < 2 * hh + a));
    endfunction

    task automatic wr_byte(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        bimg[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill8(input int seed);
        for (int i = 0; i < 32; i++) wr_byte(i, 8'((i * 37 + seed * 11 + 5) & 255));
    endtask

    task automatic fill16(input int seed);
        for (int e = 0; e < 16; e++) begin
            wr_byte(2 * e, {1'((e + seed) & 1), 7'd0});
            wr_byte(2 * e + 1, 8'((e * 5 + seed) % 9));
        end
    endtask

    // Runs one transmission and compares every cycle with the arithmetic model.
    task automatic run_tx(input bit wide, input int last, input int p, input int h,
                          input int l1, input int l2, input int bh, input int bl,
                          input int poke, input string tag);
        int n, total, mism, first_k, first_act;
        total = 0;
        n = wide ? ((last & 15) + 1) : (last + 1);
        for (int e = 0; e < n; e++) begin
            bit lvl;
            int u;
            if (wide) begin
                lvl = bimg[2 * e][7];
                u   = {bimg[2 * e][6:0], bimg[2 * e + 1]};
            end else begin
                lvl = bimg[e / 8][7 - (e % 8)];
                u   = lvl ? bh : bl;
            end
            if (u == 0) u = 1;
            for (int j = 0; j < u * (p + 1); j++) begin
                exp_led[total] = lvl & car_at(j, h, l1, l2);
                total++;
            end
        end
        @(negedge clk);
        cfg_wide = wide; cfg_last = 8'(last); cfg_presc = 8'(p);
        cfg_car_high = 8'(h); cfg_car_low_a = 8'(l1); cfg_car_low_b = 8'(l2);
        cfg_base_hi = 8'(bh); cfg_base_lo = 8'(bl);
        @(negedge clk);
        start = 1'b1;
        mism = 0; first_k = -1; first_act = 0;
        for (int k = 0; k <= total; k++) begin
            @(negedge clk);
            start = (k == poke) ? 1'b1 : 1'b0;
            if (k < total) begin
                if (!busy || (led !== exp_led[k])) begin
                    mism++;
                    if (first_k < 0) begin first_k = k; first_act = {busy, led}; end
                end
            end else begin
                check(!busy && !led, {tag, " R8 busy falls after total cycles"},
                      int'({busy, led}), 0);
            end
        end
        start = 1'b0;
        check(mism == 0, {tag, " R7 waveform (first bad cycle in actual, busy/led in expected)"},
              first_k, first_act);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(led == 1'b0, "R1 led in reset", led, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !led, "R1 idle after reset", int'({busy, led}), 0);

        // R2 R3 R4 R5: narrow mode sweep over prescale and carrier shape.
        for (int p = 0; p < 3; p++)
            for (int h = 1; h < 4; h++)
                for (int d = 0; d < 2; d++) begin
                    fill8(p * 7 + h * 3 + d);
                    run_tx(0, 15, p, h, h + 1, h + 1 + d, 3, 2, -1, "R2 R3 R4 R5");
                end
        // R2 R5: zero-valued fields act as one.
        fill8(3);
        run_tx(0, 7, 0, 0, 0, 0, 0, 0, -1, "R2 R5 zero fields");
        // R10: whole buffer in narrow mode.
        fill8(9);
        run_tx(0, 255, 0, 1, 1, 2, 1, 1, -1, "R10 full narrow");
        // R6: wide mode with all entries, including zero durations.
        for (int p = 0; p < 3; p++) begin
            fill16(p);
            run_tx(1, 15, p, 2, 3, 2, 0, 0, -1, "R6 R4 wide");
        end
        // R10: upper bits of the last index are ignored in wide mode.
        fill16(1);
        run_tx(1, 8'hF3, 1, 1, 2, 3, 0, 0, -1, "R10 R6 wide last");
        // R9: start pulse during a transmission.
        fill8(4);
        run_tx(0, 15, 1, 2, 3, 4, 2, 2, 10, "R9 start ignored");
        fill16(2);
        run_tx(1, 7, 0, 3, 2, 2, 0, 0, 5, "R9 wide start ignored");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule